// File: doc/BRIEF.md
# Multicart MMC3-Style Register File and Scanline IRQ

This block is the processor-facing register logic of a bank-switching cartridge controller built around an MMC3-style core with an outer register bank. It watches processor writes. Writes into the $5000–$5FFF window go to four outer registers, but only when one selectable address bit is set. The position of that bit is chosen by a 3-bit configuration-switch input. Writes in that window without the selected bit are flagged for the work RAM instead.

Writes in $8000–$FFFF always load a discrete latch. They also reach the control register, the twelve bank registers, the mirroring register, the RAM-configuration register and the scanline interrupt logic. Which of these is hit is decoded from address bits 14, 13 and 0.

The interrupt counter advances on a single-cycle scanline pulse supplied by the surrounding logic. The interrupt output stays high until it is acknowledged. Bank address generation is done elsewhere from the register contents that this block exposes.

Top module: `mmc_regs_irq`

## Requirements
- R1: A write to $5000–$5FFF whose address bit (4 + `cfg_sw`) is 1 stores the data byte in outer register `addr[1:0]`.
- R2: A write to $5000–$5FFF whose address bit (4 + `cfg_sw`) is 0 changes no outer register and raises `wram_wr` combinationally in the same cycle; `wram_wr` is low for any other access.
- R3: Every write to $8000–$FFFF loads `latch_q` with the data byte, whatever other effect it has, including ignored writes.
- R4: Writes decoded to the control/bank-data pair (`addr[14:13]` = 00) are ignored when `addr[1]` is 1; `addr[0]` = 0 selects control, 1 selects bank data.
- R5: A bank-data write stores into bank register i, with i = `ctrl_q[3:0]` when outer register 3 bit 1 is set and i = `ctrl_q[2:0]` otherwise; indices 12 to 15 write nothing.
- R6: `addr[14:13]` = 01 with `addr[0]` = 0 stores the byte in `mirr_q`; with `addr[0]` = 1 it stores it in `ramcfg_q`, keeping only bits 7:6 (the rest zero) when data bit 5 is 0.
- R7: `addr[14:13]` = 10: `addr[0]` = 0 sets the reload value `reload_q`, `addr[0]` = 1 requests a reload. `addr[14:13]` = 11: `addr[0]` = 0 disables the interrupt and drops `irq`, `addr[0]` = 1 enables it.
- R8: On a `scan_tick`, the counter takes the reload value if it is zero or a reload was requested, and otherwise decrements. If the new count is zero and the interrupt is enabled, `irq` rises the next cycle. The reload request then clears.
- R9: Once high, `irq` stays high until a disable write ($E000 decode) or reset.
- R10: After reset the bank registers hold 0, 2, 4, 5, 6, 7, 0, 1, FE, FF, FF, FF (index 0 to 11), `ramcfg_q` = 80, and outer, control, mirroring, latch, reload and interrupt state are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Processor write strobe, one cycle per write |
| wr_addr | input | 16 | Write address |
| wr_data | input | DW | Write data |
| cfg_sw | input | 3 | Configuration switch selecting the outer-register address bit |
| scan_tick | input | 1 | Filtered scanline clock pulse |
| outer_q | output | 4*DW | Outer registers, register k at bits k*DW+: DW |
| bank_q | output | 12*DW | Bank registers, register i at bits i*DW+: DW |
| ctrl_q | output | DW | Control register |
| mirr_q | output | DW | Mirroring register |
| ramcfg_q | output | DW | RAM-configuration register |
| latch_q | output | DW | Discrete latch |
| reload_q | output | DW | Interrupt reload value |
| wram_wr | output | 1 | Write in $5000–$5FFF passed through to work RAM |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench builds the block with its default data width of 8. At that width the reset constants FE and FF and the bit-5 mask on the RAM-configuration write have their intended meaning. All eight switch positions are driven, so the outer-register select bit is taken from every position from bit 4 up to bit 11. Both index widths are covered, including the out-of-range indices 12 to 15. Reload values of zero and of nonzero values are exercised, as are scanline pulses that land in the same cycle as interrupt writes.

// File: rtl/mmc_regs_irq.sv
module mmc_regs_irq #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [15:0]     wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [2:0]      cfg_sw,
  input  logic            scan_tick,
  output logic [4*DW-1:0] outer_q,
  output logic [12*DW-1:0] bank_q,
  output logic [DW-1:0]   ctrl_q,
  output logic [DW-1:0]   mirr_q,
  output logic [DW-1:0]   ramcfg_q,
  output logic [DW-1:0]   latch_q,
  output logic [DW-1:0]   reload_q,
  output logic            wram_wr,
  output logic            irq
);

  localparam int NOUT  = 4;
  localparam int NBANK = 12;

  function automatic logic [DW-1:0] bank_init(input int i);
    case (i)
      0: return DW'(0);
      1: return DW'(2);
      2: return DW'(4);
      3: return DW'(5);
      4: return DW'(6);
      5: return DW'(7);
      6: return DW'(0);
      7: return DW'(1);
      8: return {{(DW-1){1'b1}}, 1'b0};
      default: return {DW{1'b1}};
    endcase
  endfunction

  logic [DW-1:0] outer_r [NOUT];
  logic [DW-1:0] bank_r  [NBANK];
  logic [DW-1:0] cnt_r;
  logic          rld_req, irq_en;

  wire lo_win    = wr_en && (wr_addr[15:12] == 4'h5);
  wire outer_hit = lo_win && wr_addr[4 + cfg_sw];
  wire hi_win    = wr_en && wr_addr[15];
  wire [2:0] sel = {wr_addr[14:13], wr_addr[0]};
  wire pair_blk  = (sel[2:1] == 2'b00) && wr_addr[1];
  wire hi_act    = hi_win && !pair_blk;
  wire ext_idx   = outer_r[3][1];
  wire [3:0] idx = ext_idx ? ctrl_q[3:0] : {1'b0, ctrl_q[2:0]};
  wire [DW-1:0] ram_d = wr_data[5] ? wr_data : {wr_data[DW-1:DW-2], {(DW-2){1'b0}}};
  wire cnt_load  = (cnt_r == '0) || rld_req;
  wire [DW-1:0] cnt_nx = cnt_load ? reload_q : cnt_r - 1'b1;
  wire irq_ack   = hi_win && (sel == 3'b110);

  assign wram_wr = lo_win && !outer_hit;

  for (genvar k = 0; k < NOUT; k++) begin : g_out
    assign outer_q[k*DW +: DW] = outer_r[k];
  end
  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    assign bank_q[i*DW +: DW] = bank_r[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NOUT; k++) outer_r[k] <= '0;
      for (int i = 0; i < NBANK; i++) bank_r[i] <= bank_init(i);
      ctrl_q   <= '0;
      mirr_q   <= '0;
      ramcfg_q <= DW'(8'h80);
      latch_q  <= '0;
      reload_q <= '0;
      cnt_r    <= '0;
      rld_req  <= 1'b0;
      irq_en   <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (outer_hit) outer_r[wr_addr[1:0]] <= wr_data;
      if (hi_win) latch_q <= wr_data;
      if (hi_act) begin
        case (sel)
          3'b000: ctrl_q <= wr_data;
          3'b001: if (idx < 4'(NBANK)) bank_r[idx] <= wr_data;
          3'b010: mirr_q <= wr_data;
          3'b011: ramcfg_q <= ram_d;
          3'b100: reload_q <= wr_data;
          3'b110: irq_en <= 1'b0;
          3'b111: irq_en <= 1'b1;
          default: ;
        endcase
      end
      if (scan_tick) cnt_r <= cnt_nx;
      if (hi_win && sel == 3'b101) rld_req <= 1'b1;
      else if (scan_tick) rld_req <= 1'b0;
      if (irq_ack) irq <= 1'b0;
      else if (scan_tick && cnt_nx == '0 && irq_en) irq <= 1'b1;
    end
  end

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_ack |=> irq);

  // R7
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq);

  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq && !scan_tick |=> !irq);

  // R3
  latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr[15] |=> latch_q == $past(wr_data));

  // R4
  pair_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr[15] && wr_addr[14:13] == 2'b00 && wr_addr[1]
      |=> $stable(ctrl_q) && $stable(bank_q));

  // R2
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wram_wr |=> $stable(outer_q));

endmodule

// File: tb/mmc_regs_irq_tb.sv
`timescale 1ns/1ps
module mmc_regs_irq_tb;
  logic        clk = 0, rst_n = 0, wr_en = 0, scan_tick = 0;
  logic [15:0] wr_addr = 0;
  logic [7:0]  wr_data = 0;
  logic [2:0]  cfg_sw = 0;
  logic [31:0] outer_q;
  logic [95:0] bank_q;
  logic [7:0]  ctrl_q, mirr_q, ramcfg_q, latch_q, reload_q;
  logic        wram_wr, irq;

  mmc_regs_irq #(.DW(8)) u_dut (.*);

  always #4 clk = ~clk;

  int nchk = 0, nerr = 0;
  bit done = 0;
  int m_outer[4], m_bank[12];
  int m_ctrl, m_mirr, m_ram, m_latch, m_rld, m_cnt;
  bit m_req, m_en, m_irq;

  task automatic chk(string tag, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    int init[12] = '{0, 2, 4, 5, 6, 7, 0, 1, 'hFE, 'hFF, 'hFF, 'hFF};
    for (int k = 0; k < 4; k++) m_outer[k] = 0;
    for (int i = 0; i < 12; i++) m_bank[i] = init[i];
    m_ctrl = 0; m_mirr = 0; m_ram = 'h80; m_latch = 0; m_rld = 0; m_cnt = 0;
    m_req = 0; m_en = 0; m_irq = 0;
  endtask

  task automatic model_step(bit we, int a, int d, bit tk);
    if (tk) begin
      if (m_cnt == 0 || m_req) m_cnt = m_rld; else m_cnt = (m_cnt - 1) & 255;
      if (m_cnt == 0 && m_en) m_irq = 1;
      m_req = 0;
    end
    if (we && a >= 'h5000 && a < 'h6000 && ((a >> (4 + cfg_sw)) & 1))
      m_outer[a & 3] = d;
    if (we && a >= 'h8000) begin
      int r;
      m_latch = d;
      r = a & 'hE001;
      if (!((r == 'h8000 || r == 'h8001) && (a & 2))) begin
        case (r)
          'h8000: m_ctrl = d;
          'h8001: begin
            int i;
            i = m_ctrl & ((m_outer[3] & 2) ? 15 : 7);
            if (i < 12) m_bank[i] = d;
          end
          'hA000: m_mirr = d;
          'hA001: m_ram = (d & 'h20) ? d : (d & 'hC0);
          'hC000: m_rld = d;
          'hC001: m_req = 1;
          'hE000: begin m_en = 0; m_irq = 0; end
          'hE001: m_en = 1;
          default: ;
        endcase
      end
    end
  endtask

  task automatic compare_all();
    for (int k = 0; k < 4; k++) chk("R1 outer register", outer_q[k*8 +: 8], m_outer[k]);
    for (int i = 0; i < 12; i++) chk("R5 bank register", bank_q[i*8 +: 8], m_bank[i]);
    chk("R4 control", ctrl_q, m_ctrl);
    chk("R6 mirroring", mirr_q, m_mirr);
    chk("R6 ram config", ramcfg_q, m_ram);
    chk("R3 latch", latch_q, m_latch);
    chk("R7 reload value", reload_q, m_rld);
    chk("R8 irq", irq, m_irq);
  endtask

  task automatic cyc(bit we, int a, int d, bit tk);
    bit exp_w;
    wr_en = we; wr_addr = a[15:0]; wr_data = d[7:0]; scan_tick = tk;
    #1;
    exp_w = we && a >= 'h5000 && a < 'h6000 && !((a >> (4 + cfg_sw)) & 1);
    chk("R2 pass-through strobe", wram_wr, exp_w);
    @(posedge clk); @(negedge clk);
    model_step(we, a, d, tk);
    compare_all();
    wr_en = 0; scan_tick = 0;
  endtask

  task automatic wr(int a, int d); cyc(1, a, d, 0); endtask
  task automatic tick(); cyc(0, 0, 0, 1); endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    chk("R10 bank8 after reset", bank_q[8*8 +: 8], 'hFE);
    chk("R10 ramcfg after reset", ramcfg_q, 'h80);
    chk("R10 irq after reset", irq, 0);
    compare_all();

    // R1 / R2 across all switch positions
    for (int s = 0; s < 8; s++) begin
      cfg_sw = s[2:0];
      wr('h5000 | (1 << (4 + s)) | (s & 3), 'h10 + s);
      chk("R1 selected outer write", outer_q[(s & 3)*8 +: 8], 'h10 + s);
      wr('h5000 | (1 << (4 + ((s + 1) % 8))) | (s & 3), 'hEE);
      chk("R2 outer unchanged", outer_q[(s & 3)*8 +: 8], 'h10 + s);
    end
    cfg_sw = 0;
    wr('h5013, 'h00);

    // R5 normal index width
    for (int k = 0; k < 8; k++) begin
      wr('h8000, k); wr('h8001, 'h40 + k);
    end
    wr('h8000, 'h0A); wr('h8001, 'h99);
    chk("R5 narrow index uses low 3 bits", bank_q[2*8 +: 8], 'h99);
    // R5 extended index width
    wr('h5013, 'h02);
    for (int k = 8; k < 16; k++) begin
      wr('h8000, k); wr('h8001, 'h60 + k);
    end
    chk("R5 extended index 11", bank_q[11*8 +: 8], 'h6B);

    // R4 ignored pair writes, R3 latch still loads
    wr('h8002, 'h55);
    chk("R4 control ignored with A1", ctrl_q, 15);
    chk("R3 latch on ignored write", latch_q, 'h55);
    wr('h9FFF, 'h77);
    chk("R4 bank data ignored with A1", bank_q[7*8 +: 8], 'h47);

    // R6
    wr('hA000, 'h01);
    wr('hA001, 'hDF);
    chk("R6 masked ram config", ramcfg_q, 'hC0);
    wr('hA001, 'h27);
    chk("R6 unmasked ram config", ramcfg_q, 'h27);

    // R7 / R8 counter
    wr('hC000, 3); wr('hC001, 0); wr('hE001, 0);
    for (int t = 0; t < 3; t++) tick();
    chk("R8 no irq before zero", irq, 0);
    tick();
    chk("R8 irq at zero", irq, 1);
    // R9 sticky
    for (int t = 0; t < 5; t++) tick();
    repeat (4) wr('hC000, 5);
    chk("R9 irq held", irq, 1);
    wr('hE000, 0);
    chk("R7 disable clears irq", irq, 0);
    tick(); tick();
    chk("R7 disabled counter no irq", irq, 0);
    wr('hC000, 0); wr('hC001, 0); wr('hE001, 0);
    tick();
    chk("R8 zero reload irq", irq, 1);
    cyc(1, 'hE000, 0, 1);
    chk("R7 ack beats tick", irq, 0);

    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      int a, sel;
      sel = $urandom % 5;
      if (sel == 0) a = 'h5000 | ($urandom & 'hFFF);
      else if (sel == 1) a = 'hC000 | ($urandom & 'h3FFF);
      else a = 'h8000 | ($urandom & 'h7FFF);
      if ($urandom % 50 == 0) cfg_sw = 3'($urandom);
      cyc($urandom % 3 != 0, a, $urandom & 255, $urandom % 3 == 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule